// File: doc/BRIEF.md
# Buffered Comparator PWM Channel

This block is one pulse-width output channel that sits beside a shared free-running counter. It never counts itself. It takes the low byte of that counter and the counter's wrap strobe as inputs. An internal magnitude comparator checks the counter byte against an active threshold and sets the output pin from the result. The output is low while the count is below the threshold, and high once the count reaches it.

Software sets the duty by writing a reload byte. The active threshold is never written directly. The channel copies the reload byte into the active threshold only on the cycle the counter wraps, so a duty change always starts at a period boundary and never cuts a period short. A seven-bit mode register decides whether the channel runs as a PWM. Any other mode setting parks the output high and freezes the threshold.

Top module: `pwm_cmp_chan`

## Requirements
- R1: When reset (rst_n low) is released, the reload byte, the active threshold and the mode register all read zero, and pwm_out is 1.
- R2: A write with wr_sel=0 stores wr_data into the reload byte, which reads back on the next cycle. Without a qualified wrap, the active threshold keeps its value.
- R3: When cnt_wrap is high and the channel is in PWM mode, the active threshold takes the reload byte's value at the next clock edge.
- R4: In PWM mode, pwm_out is 0 when cnt_lo is below the active threshold and 1 when cnt_lo is at or above it. The output follows cnt_lo in the same cycle.
- R5: PWM mode requires mode bit 0 (PWM enable) and mode bit 1 (compare enable) both set and mode bits 6..2 all clear. In any other mode, pwm_out is 1 and a wrap leaves the active threshold unchanged.
- R6: If a reload write and a qualified wrap fall in the same cycle, the active threshold takes the reload value from before that write. The new value moves across on the following qualified wrap.
- R7: Over one full 256-count sweep of cnt_lo, pwm_out is high for 256 minus the threshold counts. A threshold of 0 gives a constant high output, and a threshold of 0xFF gives exactly one high count.
- R8: A write with wr_sel=1 stores wr_data[6:0] into the mode register and ignores wr_data[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_lo | input | 8 | Low byte of the shared counter |
| cnt_wrap | input | 1 | One-cycle strobe when the shared counter wraps |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the reload byte, 1 selects the mode register |
| wr_data | input | 8 | Write data |
| reload_q | output | 8 | Reload byte readback |
| active_q | output | 8 | Active threshold readback |
| mode_q | output | 7 | Mode register readback |
| pwm_out | output | 1 | PWM output pin |

## Verification
Several properties are checked on every cycle. While the channel is in PWM mode, the output must agree with the comparison of the count against the threshold. A qualified wrap must load the reload byte that was present before the edge, the threshold must not move at any other time, and a parked channel must hold its output high. Other behaviour only shows across a sequence of stimulus, so the bench scenarios cover it: high-time counts over a full sweep for every threshold value, the ordering when a write and a wrap collide, and the mode settings that must keep the channel parked.

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int W = 8,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt_lo,
  input  logic          cnt_wrap,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  reload_q,
  output logic [W-1:0]  active_q,
  output logic [MW-1:0] mode_q,
  output logic          pwm_out
);
  localparam int PWM_BIT = 0;
  localparam int CMP_BIT = 1;

  logic pwm_on;
  assign pwm_on = mode_q[PWM_BIT] & mode_q[CMP_BIT] & ~|mode_q[MW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel) mode_q   <= wr_data[MW-1:0];
      else        reload_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                active_q <= '0;
    else if (cnt_wrap && pwm_on) active_q <= reload_q;
  end

  assign pwm_out = ~pwm_on | (cnt_lo >= active_q);
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int W = 8,
  parameter int MW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  cnt_lo,
  input logic          cnt_wrap,
  input logic [W-1:0]  reload_q,
  input logic [W-1:0]  active_q,
  input logic [MW-1:0] mode_q,
  input logic          pwm_out
);
  logic run;
  assign run = (mode_q[1:0] == 2'b11) && (mode_q[MW-1:2] == '0);

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (reload_q == '0 && active_q == '0 && mode_q == '0 && pwm_out));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_wrap && run) |=> $stable(active_q));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wrap && run) |=> active_q == $past(reload_q));

  a_r4_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_lo < active_q) |-> !pwm_out);

  a_r4_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_lo >= active_q) |-> pwm_out);

  a_r5_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out);
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.W(W), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cnt_wrap(cnt_wrap),
  .reload_q(reload_q), .active_q(active_q), .mode_q(mode_q), .pwm_out(pwm_out)
);

// File: tb/pwm_cmp_chan_tb.sv
module pwm_cmp_chan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt_lo = '0;
  logic       cnt_wrap = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] reload_q, active_q;
  logic [6:0] mode_q;
  logic       pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_cmp_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cnt_wrap(cnt_wrap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload_q(reload_q), .active_q(active_q), .mode_q(mode_q), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wrap();
    cnt_wrap = 1'b1;
    tick();
    cnt_wrap = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int highs;
    logic [7:0] prev;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reload", reload_q, 0);
    chk("R1 active", active_q, 0);
    chk("R1 mode", mode_q, 0);
    chk("R1 out", pwm_out, 1);

    wr(1'b1, 8'h83);
    chk("R8 mode bit7 ignored", mode_q, 3);

    for (int d = 0; d < 256; d++) begin
      prev = active_q;
      wr(1'b0, d[7:0]);
      chk("R2 reload readback", reload_q, d);
      chk("R2 active held", active_q, prev);
      wrap();
      chk("R3 load on wrap", active_q, d);
      highs = 0;
      for (int c = 0; c < 256; c++) begin
        cnt_lo = c[7:0];
        #1;
        chk("R4 compare", pwm_out, (c >= d) ? 1 : 0);
        if (pwm_out) highs++;
      end
      chk("R7 high count", highs, 256 - d);
    end

    // R6: write and wrap in the same cycle
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h40; cnt_wrap = 1'b1;
    tick();
    wr_en = 1'b0; cnt_wrap = 1'b0;
    chk("R6 old reload taken", active_q, 8'hFF);
    chk("R6 new reload stored", reload_q, 8'h40);
    wrap();
    chk("R6 next wrap", active_q, 8'h40);

    // R5: non-PWM modes park the output and freeze the threshold
    foreach (prev[i]) ;
    for (int m = 0; m < 6; m++) begin
      logic [7:0] mv;
      case (m)
        0: mv = 8'h00;
        1: mv = 8'h01;
        2: mv = 8'h02;
        3: mv = 8'h07;
        4: mv = 8'h43;
        default: mv = 8'h13;
      endcase
      wr(1'b1, mv);
      wr(1'b0, 8'h10);
      wrap();
      chk("R5 active frozen", active_q, 8'h40);
      cnt_lo = 8'h00; #1;
      chk("R5 out parked high", pwm_out, 1);
      wr(1'b0, 8'h40);
    end

    wr(1'b1, 8'h03);
    cnt_lo = 8'h3F; #1;
    chk("R4 below after re-enable", pwm_out, 0);
    finish_run();
  end
endmodule